// File: doc/BRIEF.md
# Macro-Call Collector for a Command Method Stream

This block sits behind a command front end that issues method writes. Each write carries a method index, a 32-bit value and a count of parameters still to come. Indices below a configurable register limit are plain register writes and are forwarded to a register-file write port. Indices at or above the macro boundary (0xE00 by default) are macro calls, and each call uses a pair of methods. Entry n of the uploaded macro table starts at trigger method 0xE00 + 2n, and the odd index after it carries the remaining arguments.

The collector checks that each call follows the protocol. It stores the call's values in a 16-word parameter buffer. When the word with a zero remaining-count arrives, the block raises a dispatch pulse that gives the macro entry number and the parameter count. The buffer can be read by index while that pulse is high. A protocol violation raises an error pulse with a reason code, abandons any call in progress and returns the block to idle. The collector does not run macro code and does not perform register side effects.

All outputs are registered. A write accepted at a clock edge shows its effect on the outputs during the cycle that follows that edge.

Top module: `macro_call_collector`

## Requirements
- R1: After reset, reg_we_o, disp_valid_o and err_valid_o are all low, and the block is idle with no call open.
- R2: A valid write to a method below REG_COUNT (0xC00 by default) produces reg_we_o high for one cycle after the accepting edge, with reg_addr_o equal to the method and reg_wdata_o equal to the value. It produces no dispatch and no error.
- R3: When idle, a valid write to a method in the range [REG_COUNT, MACRO_BASE) is not forwarded to the register port. It raises err_valid_o for one cycle with err_code_o = 3.
- R4: When idle, a valid write to an odd method at or above MACRO_BASE raises err_valid_o with err_code_o = 1. It opens no call and stores no parameter.
- R5: When idle, a valid write to an even method at or above MACRO_BASE opens a call. That value and each later value written to the trigger index plus one are stored in arrival order at buffer index 0, 1, 2 and so on.
- R6: A stored write whose remaining-count is zero ends the call. In the next cycle disp_valid_o is high for one cycle, with disp_id_o = (trigger - MACRO_BASE)/2 and disp_count_o equal to the number of stored words. rd_data_o returns word rd_idx_i during that cycle.
- R7: While a call is open, a valid write to any method other than the trigger index plus one raises err_valid_o with err_code_o = 2. The call is abandoned, and the offending write is neither stored nor forwarded.
- R8: After a dispatch or an abort, the next call starts again at buffer index 0 with a count of zero and a clear overflow flag.
- R9: Words beyond DEPTH (16) in one call are dropped. The call dispatches with disp_count_o = DEPTH and disp_ovf_o = 1. disp_ovf_o is 0 for a call that fits.
- R10: A trigger write whose remaining-count is already zero dispatches at once with disp_count_o = 1.
- R11: A cycle with in_valid_i low changes no state and produces no register write, dispatch or error, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A method write is present this cycle |
| in_method_i | input | METHOD_W (13) | Method index |
| in_value_i | input | DATA_W (32) | Method value |
| in_remaining_i | input | REM_W (16) | Parameters still to follow this one |
| reg_we_o | output | 1 | Register-file write strobe |
| reg_addr_o | output | METHOD_W | Register index |
| reg_wdata_o | output | DATA_W | Register value |
| disp_valid_o | output | 1 | One-cycle macro dispatch pulse |
| disp_id_o | output | METHOD_W-1 | Macro entry number |
| disp_count_o | output | clog2(DEPTH+1) | Number of stored parameters |
| disp_ovf_o | output | 1 | Parameters were dropped in this call |
| rd_idx_i | input | clog2(DEPTH) | Parameter buffer read index |
| rd_data_o | output | DATA_W | Parameter word at rd_idx_i |
| err_valid_o | output | 1 | One-cycle protocol error pulse |
| err_code_o | output | 2 | 1 odd start, 2 foreign write in a call, 3 index in the gap |

## Verification
The assertions watch, on every cycle, for these conditions: a dispatch pulse not preceded by a zero remaining-count write, a dispatch and an error pulse at the same time, a register strobe to an index at or beyond the limit, any activity after an idle input cycle, and a foreign write during a call that is not reported as an interruption. Several behaviours can only be shown by the bench's scenarios, which a behavioural model compares on every clock. These are the order and content of stored words, the entry number arithmetic up to the top trigger index, dropping past sixteen words, and the cleared state after a dispatch or an abort.

// File: rtl/macro_call_pkg.sv
package macro_call_pkg;
    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_ARG_START = 2'd1,
        ERR_INTERRUPT = 2'd2,
        ERR_REG_RANGE = 2'd3
    } mc_err_e;
endpackage

// File: rtl/mcc_classifier.sv
module mcc_classifier #(
    parameter int METHOD_W   = 13,
    parameter int MACRO_BASE = 'hE00,
    parameter int REG_COUNT  = 'hC00
) (
    input  logic [METHOD_W-1:0] method_i,
    input  logic [METHOD_W-1:0] act_m_i,
    output logic                is_reg_o,
    output logic                is_trig_o,
    output logic                is_odd_o,
    output logic                is_cont_o
);
    localparam logic [METHOD_W-1:0] BASE_M = METHOD_W'(MACRO_BASE);
    localparam logic [METHOD_W-1:0] REG_M  = METHOD_W'(REG_COUNT);

    always_comb begin
        is_reg_o  = method_i < REG_M;
        is_trig_o = method_i >= BASE_M;
        is_odd_o  = method_i[0];
        is_cont_o = method_i == (act_m_i + METHOD_W'(1));
    end
endmodule

// File: rtl/mcc_param_buf.sv
module mcc_param_buf #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
            end else if (we_i && widx_i == IDX_W'(e)) begin
                mem_q[e] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/macro_call_collector.sv
module macro_call_collector
    import macro_call_pkg::*;
#(
    parameter int METHOD_W   = 13,
    parameter int DATA_W     = 32,
    parameter int REM_W      = 16,
    parameter int MACRO_BASE = 'hE00,
    parameter int REG_COUNT  = 'hC00,
    parameter int DEPTH      = 16,
    localparam int ID_W   = METHOD_W - 1,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [METHOD_W-1:0] in_method_i,
    input  logic [DATA_W-1:0]   in_value_i,
    input  logic [REM_W-1:0]    in_remaining_i,
    output logic                reg_we_o,
    output logic [METHOD_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0]   reg_wdata_o,
    output logic                disp_valid_o,
    output logic [ID_W-1:0]     disp_id_o,
    output logic [CNT_W-1:0]    disp_count_o,
    output logic                disp_ovf_o,
    input  logic [IDX_W-1:0]    rd_idx_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                err_valid_o,
    output logic [1:0]          err_code_o
);
    localparam logic [METHOD_W-1:0] BASE_M  = METHOD_W'(MACRO_BASE);
    localparam logic [ID_W-1:0]     BASE_HI = BASE_M[METHOD_W-1:1];
    localparam logic [CNT_W-1:0]    DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic                active;
        logic [METHOD_W-1:0] act_m;
        logic [CNT_W-1:0]    cnt;
        logic                ovf;
        logic                reg_we;
        logic [METHOD_W-1:0] reg_addr;
        logic [DATA_W-1:0]   reg_wdata;
        logic                disp_valid;
        logic [ID_W-1:0]     disp_id;
        logic [CNT_W-1:0]    disp_cnt;
        logic                disp_ovf;
        logic                err_valid;
        mc_err_e             err_code;
    } st_t;

    st_t st_d, st_q;

    logic is_reg, is_trig, is_odd, is_cont;
    logic store, finish, buf_we;

    mcc_classifier #(
        .METHOD_W  (METHOD_W),
        .MACRO_BASE(MACRO_BASE),
        .REG_COUNT (REG_COUNT)
    ) u_class (
        .method_i (in_method_i),
        .act_m_i  (st_q.act_m),
        .is_reg_o (is_reg),
        .is_trig_o(is_trig),
        .is_odd_o (is_odd),
        .is_cont_o(is_cont)
    );

    mcc_param_buf #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (buf_we),
        .widx_i (st_q.cnt[IDX_W-1:0]),
        .wdata_i(in_value_i),
        .ridx_i (rd_idx_i),
        .rdata_o(rd_data_o)
    );

    always_comb begin
        st_d            = st_q;
        st_d.reg_we     = 1'b0;
        st_d.disp_valid = 1'b0;
        st_d.err_valid  = 1'b0;
        store           = 1'b0;
        finish          = 1'b0;
        buf_we          = 1'b0;

        if (in_valid_i) begin
            if (st_q.active) begin
                if (is_cont) begin
                    store  = 1'b1;
                    finish = in_remaining_i == '0;
                end else begin
                    st_d.err_valid = 1'b1;
                    st_d.err_code  = ERR_INTERRUPT;
                    st_d.active    = 1'b0;
                    st_d.cnt       = '0;
                    st_d.ovf       = 1'b0;
                end
            end else if (is_trig) begin
                if (is_odd) begin
                    st_d.err_valid = 1'b1;
                    st_d.err_code  = ERR_ARG_START;
                end else begin
                    st_d.active = 1'b1;
                    st_d.act_m  = in_method_i;
                    store       = 1'b1;
                    finish      = in_remaining_i == '0;
                end
            end else if (is_reg) begin
                st_d.reg_we    = 1'b1;
                st_d.reg_addr  = in_method_i;
                st_d.reg_wdata = in_value_i;
            end else begin
                st_d.err_valid = 1'b1;
                st_d.err_code  = ERR_REG_RANGE;
            end
        end

        if (store) begin
            if (st_q.cnt < DEPTH_C) begin
                buf_we   = 1'b1;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.ovf = 1'b1;
            end
        end

        if (finish) begin
            st_d.disp_valid = 1'b1;
            st_d.disp_id    = st_q.active ? (st_q.act_m[METHOD_W-1:1] - BASE_HI)
                                          : (in_method_i[METHOD_W-1:1] - BASE_HI);
            st_d.disp_cnt   = st_d.cnt;
            st_d.disp_ovf   = st_d.ovf;
            st_d.active     = 1'b0;
            st_d.cnt        = '0;
            st_d.ovf        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_we_o     = st_q.reg_we;
    assign reg_addr_o   = st_q.reg_addr;
    assign reg_wdata_o  = st_q.reg_wdata;
    assign disp_valid_o = st_q.disp_valid;
    assign disp_id_o    = st_q.disp_id;
    assign disp_count_o = st_q.disp_cnt;
    assign disp_ovf_o   = st_q.disp_ovf;
    assign err_valid_o  = st_q.err_valid;
    assign err_code_o   = st_q.err_code;

    // R6
    disp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> $past(in_valid_i && in_remaining_i == '0));

    // R9
    disp_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> (disp_count_o <= DEPTH_C && disp_count_o != '0));

    // R2
    reg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (reg_addr_o < METHOD_W'(REG_COUNT)));

    // R7
    intrude_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && in_valid_i && !is_cont) |=> (err_valid_o && err_code_o == ERR_INTERRUPT));

    // R7
    disp_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_valid_o && err_valid_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !(reg_we_o || disp_valid_o || err_valid_o));
endmodule

// File: tb/macro_call_collector_tb.sv
`timescale 1ns/100ps
module macro_call_collector_tb_top;
    localparam int BASE = 'hE00;
    localparam int REGN = 'hC00;
    localparam int DEP  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [12:0] in_method = '0;
    logic [31:0] in_value = '0;
    logic [15:0] in_rem = '0;
    logic        reg_we;
    logic [12:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        disp_valid;
    logic [11:0] disp_id;
    logic [4:0]  disp_count;
    logic        disp_ovf;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        err_valid;
    logic [1:0]  err_code;

    macro_call_collector dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_method_i(in_method), .in_value_i(in_value),
        .in_remaining_i(in_rem),
        .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .disp_valid_o(disp_valid), .disp_id_o(disp_id), .disp_count_o(disp_count),
        .disp_ovf_o(disp_ovf), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .err_valid_o(err_valid), .err_code_o(err_code)
    );

    always #10 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    int m_act = -1;
    int m_q[$];
    bit m_ovf = 0;
    // expected outputs for the coming cycle
    bit e_we, e_disp, e_err, e_ovf;
    int e_addr, e_data, e_id, e_cnt, e_code;
    int e_words[$];

    task automatic chk(input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("reg_we", int'(reg_we), int'(e_we));
        chk("disp_valid", int'(disp_valid), int'(e_disp));
        chk("err_valid", int'(err_valid), int'(e_err));
        if (e_we && reg_we) begin
            chk("reg_addr", int'(reg_addr), e_addr);
            chk("reg_wdata", int'(reg_wdata), e_data);
        end
        if (e_err && err_valid) chk("err_code", int'(err_code), e_code);
        if (e_disp && disp_valid) begin
            chk("disp_id", int'(disp_id), e_id);
            chk("disp_count", int'(disp_count), e_cnt);
            chk("disp_ovf", int'(disp_ovf), int'(e_ovf));
            for (int i = 0; i < e_words.size(); i++) begin
                rd_idx = 4'(i);
                #0.5;
                chk($sformatf("word%0d", i), int'(rd_data), e_words[i]);
            end
        end
    endtask

    function automatic void model(input bit v, input int m, input int val, input int rem);
        bit st, fin;
        e_we = 0; e_disp = 0; e_err = 0; st = 0; fin = 0;
        if (!v) return;
        if (m_act >= 0) begin
            if (m == m_act + 1) begin st = 1; fin = (rem == 0); end
            else begin e_err = 1; e_code = 2; m_act = -1; m_q.delete(); m_ovf = 0; end
        end else if (m >= BASE) begin
            if (m % 2 == 1) begin e_err = 1; e_code = 1; end
            else begin m_act = m; st = 1; fin = (rem == 0); end
        end else if (m < REGN) begin
            e_we = 1; e_addr = m; e_data = val;
        end else begin
            e_err = 1; e_code = 3;
        end
        if (st) begin
            if (m_q.size() < DEP) m_q.push_back(val);
            else m_ovf = 1;
        end
        if (fin) begin
            e_disp = 1; e_id = (m_act - BASE) / 2; e_cnt = m_q.size();
            e_ovf = m_ovf; e_words = m_q;
            m_act = -1; m_q.delete(); m_ovf = 0;
        end
    endfunction

    task automatic step(input bit v, input int m, input int val, input int rem);
        @(negedge clk);
        compare_all();
        in_valid = v; in_method = 13'(m); in_value = val; in_rem = 16'(rem);
        model(v, m, val, rem);
    endtask

    task automatic call(input int trig, input int n, input int seed);
        for (int i = 0; i < n; i++)
            step(1, (i == 0) ? trig : trig + 1, seed + i * 'h101, n - 1 - i);
    endtask

    initial begin
        e_we = 0; e_disp = 0; e_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs quiet after reset
        tag = "R1";
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // R2: register writes, low and top of range
        tag = "R2";
        step(1, 'h010, 'hCAFE0001, 0);
        step(1, REGN - 1, 'h12345678, 5);
        // R11: idle cycle with busy-looking inputs
        tag = "R11";
        step(0, 'hE24, 'hDEAD, 0);
        step(0, 'h020, 'hBEEF, 0);
        // R3: gap indices
        tag = "R3";
        step(1, REGN, 1, 0);
        step(1, BASE - 1, 2, 0);
        // R4: odd start
        tag = "R4";
        step(1, BASE + 1, 3, 0);
        step(1, 'hE25, 4, 2);
        // R5 / R6: five-word call at 0xE24
        tag = "R5_R6";
        call('hE24, 5, 'hA000);
        // R10: single-word call
        tag = "R10";
        call('hE2A, 1, 'hB000);
        // R7: register write in the middle of a call
        tag = "R7";
        step(1, 'hE00, 'h11, 2);
        step(1, 'h020, 'h22, 0);
        // R8: fresh call after abort
        tag = "R8";
        call('hE02, 2, 'hC000);
        // R7: odd index of another macro during a call
        tag = "R7";
        step(1, 'hE00, 'h33, 3);
        step(1, 'hE03, 'h44, 0);
        // R11: idle gap inside a call
        tag = "R11";
        step(1, 'hE06, 'h55, 1);
        step(0, 'h030, 'h66, 0);
        step(1, 'hE07, 'h77, 0);
        // R9: overflow
        tag = "R9";
        call('hE40, 20, 'hD000);
        call('hE40, DEP, 'hD800);
        // R8: overflow flag cleared
        tag = "R8";
        call('hE42, 3, 'hE000);
        // R6: top trigger index
        tag = "R6";
        call('h1FFE, 2, 'hF000);
        // mixed traffic
        tag = "R5_R7";
        for (int k = 0; k < 400; k++) begin
            int r, mm;
            r = $urandom_range(0, 9);
            case (r)
                0, 1: mm = $urandom_range(0, REGN - 1);
                2:    mm = $urandom_range(REGN, BASE - 1);
                3:    mm = BASE + 2 * $urandom_range(0, 40) + 1;
                4:    mm = (m_act >= 0) ? m_act + 1 : BASE + 2 * $urandom_range(0, 40);
                default: mm = (m_act >= 0) ? m_act + 1 : BASE + 2 * $urandom_range(0, 40);
            endcase
            step($urandom_range(0, 7) != 0, mm, int'($urandom), $urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 20));
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule